// File: doc/BRIEF.md
# Physically Tagged Cache Read Lookup with Page-Offset Set Indexing

This block is the read lookup path of a level-one data cache whose set index and line offset both lie inside the untranslated part of a virtual address. A request presents a virtual address. The block takes the set number and the word number from the page-offset bits and holds that set's tags, valid bits and lines steady while the address translation unit works. When translation returns a physical page number, the block compares that number against the stored tags of the held set. It then either returns the requested 64-bit word or raises a line request toward the next memory level.

A miss stays raised until the next level delivers the whole line on the refill port. The line and its tag are written into the least recently used way of the set, and the requested word is forwarded to the requester in the same step. A translation response that reports a translation-buffer miss does not end the wait. The lookup stays parked until a response arrives that carries a valid page number.

The controller has three states. `ST_IDLE` accepts a request and moves to `ST_WAIT_XLAT`. `ST_WAIT_XLAT` stays put on a translation miss. On a valid page number it goes back to `ST_IDLE` when a tag matches (the hit transition), or to `ST_MISS_WAIT` when none matches (the miss transition). `ST_MISS_WAIT` returns to `ST_IDLE` when refill data arrives (the fill transition).

Top module: `vipt_lookup`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `miss_valid` are 0, and every line of every set is invalid.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle `req_ready` is 0 until the lookup has produced its response. The set number is address bits 11:6, and the word number within the 64-byte line is address bits 5:3.
- R3: While a lookup waits for translation, a translation response with `xlat_hit` = 0 is ignored. On the following cycle `req_ready`, `rsp_valid` and `miss_valid` are all still 0.
- R4: On a hit, `rsp_valid` = 1 and `rsp_hit` = 1 for exactly one cycle, in the cycle after the edge that sampled the valid page number. `rsp_data` carries the selected word, where word k occupies bits k*64+63 down to k*64 of the line.
- R5: A way hits only if its valid bit is 1 and its 40-bit stored tag equals `xlat_ppn` in every bit. At most one way of a set matches.
- R6: On a miss, `miss_valid` = 1 from the cycle after the edge that sampled the page number. `miss_paddr` = {page number, set number, six zero bits}, and both hold steady until refill data is taken.
- R7: While a miss is outstanding, `fill_valid` = 1 writes `fill_data` and the page number as tag into the least recently used way of the set and marks that way valid. On the next cycle `rsp_valid` = 1 and `rsp_hit` = 0, with the selected word of `fill_data`, and `req_ready` returns to 1.
- R8: `fill_valid` has no effect when no miss is outstanding. No line, tag or response changes.
- R9: The replacement victim is the way least recently hit or filled in that set. Ways never touched since reset are chosen in descending way order, way 7 first. Every set always has exactly one victim way.
- R10: Address bits above bit 11 and below bit 3 do not affect which set or word is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_va | input | 48 | Virtual address of the request |
| req_ready | output | 1 | Block is idle and can take a request |
| xlat_valid | input | 1 | Translation response present |
| xlat_hit | input | 1 | Translation response carries a valid page number |
| xlat_ppn | input | 40 | Physical page number from translation |
| rsp_valid | output | 1 | Read response valid for one cycle |
| rsp_hit | output | 1 | 1 when the response came from a cache hit, 0 when it came from a refill |
| rsp_data | output | 64 | Requested 64-bit word |
| miss_valid | output | 1 | Line request to the next level outstanding |
| miss_paddr | output | 52 | Line-aligned physical address of the missing line |
| fill_valid | input | 1 | Refill line present |
| fill_data | input | 512 | Refill line contents |

## Verification
On every cycle the assertions check four things: a set never has two matching ways, each set has exactly one replacement victim, a response lasts one cycle and never coincides with a line request, and an outstanding line request keeps its address. They also check that a translation miss leaves the lookup parked. Only the bench's scenarios can show that the returned words are correct, that eviction follows the recency order across sequences of hits and fills, that upper and lower address bits are ignored, and that a refill arriving while idle leaves no trace.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_XLAT,
        ST_MISS_WAIT
    } lookup_state_e;
endpackage

// File: rtl/vipt_way_match.sv
module vipt_way_match #(
    parameter int WAYS  = 8,
    parameter int PPN_W = 40
) (
    input  logic [WAYS-1:0][PPN_W-1:0] tags,
    input  logic [WAYS-1:0]            valids,
    input  logic [PPN_W-1:0]           ppn,
    output logic [WAYS-1:0]            hit_vec,
    output logic                       hit,
    output logic [$clog2(WAYS)-1:0]    hit_way
);
    localparam int WAY_W = $clog2(WAYS);

    // One comparator per way, all working on the held set.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = valids[w] && (tags[w] == ppn);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/vipt_lru.sv
module vipt_lru #(
    parameter int SETS = 64,
    parameter int WAYS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(SETS)-1:0] rd_set,
    output logic [$clog2(WAYS)-1:0] victim_way,
    input  logic                    touch_en,
    input  logic [$clog2(SETS)-1:0] touch_set,
    input  logic [$clog2(WAYS)-1:0] touch_way
);
    localparam int WAY_W = $clog2(WAYS);

    // Age per way: 0 is most recent, WAYS-1 is the victim.
    logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];
    logic [WAYS-1:0]            oldest_vec;

    always_comb begin
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            oldest_vec[w] = (age_q[rd_set][w] == WAY_W'(WAYS - 1));
            if (oldest_vec[w]) victim_way = WAY_W'(w);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way) begin
                    age_q[touch_set][w] <= '0;
                end else if (age_q[touch_set][w] < age_q[touch_set][touch_way]) begin
                    age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
                end
            end
        end
    end

    // R9
    lru_single_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest_vec) == 1);
endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup #(
    parameter int VA_W       = 48,
    parameter int PPN_W      = 40,
    parameter int PAGE_OFF_W = 12,
    parameter int SETS       = 64,
    parameter int WAYS       = 8,
    parameter int LINE_BYTES = 64,
    parameter int WORD_W     = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic [VA_W-1:0]                   req_va,
    output logic                              req_ready,
    input  logic                              xlat_valid,
    input  logic                              xlat_hit,
    input  logic [PPN_W-1:0]                  xlat_ppn,
    output logic                              rsp_valid,
    output logic                              rsp_hit,
    output logic [WORD_W-1:0]                 rsp_data,
    output logic                              miss_valid,
    output logic [PPN_W+PAGE_OFF_W-1:0]       miss_paddr,
    input  logic                              fill_valid,
    input  logic [LINE_BYTES*8-1:0]           fill_data
);
    import vipt_pkg::*;

    localparam int IDX_W  = $clog2(SETS);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int WORDS  = LINE_W / WORD_W;
    localparam int WSEL_W = $clog2(WORDS);
    localparam int BSEL_W = $clog2(WORD_W / 8);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int PA_W   = PPN_W + PAGE_OFF_W;

    // Index and line offset must stay inside the untranslated bits.
    if (IDX_W + OFF_W > PAGE_OFF_W) begin : g_bad_geometry
        $error("set index and line offset exceed the page offset");
    end

    lookup_state_e state_q, state_d;

    logic [IDX_W-1:0]  idx_q;
    logic [WSEL_W-1:0] wsel_q;
    logic [PPN_W-1:0]  ppn_q;

    logic [WAYS-1:0][PPN_W-1:0] tag_q   [SETS];
    logic [WAYS-1:0]            valid_q [SETS];
    logic [LINE_W-1:0]          data_q  [SETS][WAYS];

    logic [WAYS-1:0]   hit_vec;
    logic              any_hit;
    logic [WAY_W-1:0]  hit_way;
    logic [WAY_W-1:0]  victim_way;
    logic              req_take, xlat_take, hit_take, miss_take, fill_take;
    logic [LINE_W-1:0] hit_line;
    logic [WORD_W-1:0] hit_word, fill_word;
    logic              unused_va_bits;

    assign unused_va_bits = ^{req_va[VA_W-1:PAGE_OFF_W], req_va[BSEL_W-1:0]};

    assign req_take  = (state_q == ST_IDLE) && req_valid;
    assign xlat_take = (state_q == ST_WAIT_XLAT) && xlat_valid && xlat_hit;
    assign hit_take  = xlat_take && any_hit;
    assign miss_take = xlat_take && !any_hit;
    assign fill_take = (state_q == ST_MISS_WAIT) && fill_valid;

    // Tag compare on the set held since the request was taken.
    vipt_way_match #(.WAYS(WAYS), .PPN_W(PPN_W)) u_match (
        .tags    (tag_q[idx_q]),
        .valids  (valid_q[idx_q]),
        .ppn     (xlat_ppn),
        .hit_vec (hit_vec),
        .hit     (any_hit),
        .hit_way (hit_way)
    );

    vipt_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_set     (idx_q),
        .victim_way (victim_way),
        .touch_en   (hit_take || fill_take),
        .touch_set  (idx_q),
        .touch_way  (hit_take ? hit_way : victim_way)
    );

    assign hit_line = data_q[idx_q][hit_way];

    always_comb begin
        hit_word  = '0;
        fill_word = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (wsel_q == WSEL_W'(i)) begin
                hit_word  = hit_line[i*WORD_W +: WORD_W];
                fill_word = fill_data[i*WORD_W +: WORD_W];
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = ST_WAIT_XLAT;
            ST_WAIT_XLAT: if (xlat_valid && xlat_hit)
                              state_d = any_hit ? ST_IDLE : ST_MISS_WAIT;
            ST_MISS_WAIT: if (fill_valid) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Request context
    always_ff @(posedge clk) begin
        if (req_take) begin
            idx_q  <= req_va[OFF_W +: IDX_W];
            wsel_q <= req_va[BSEL_W +: WSEL_W];
        end
        if (xlat_take) ppn_q <= xlat_ppn;
    end

    // Storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (fill_take) begin
            valid_q[idx_q][victim_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_take) begin
            tag_q[idx_q][victim_way]  <= ppn_q;
            data_q[idx_q][victim_way] <= fill_data;
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= hit_take || fill_take;
            if (hit_take) begin
                rsp_hit  <= 1'b1;
                rsp_data <= hit_word;
            end else if (fill_take) begin
                rsp_hit  <= 1'b0;
                rsp_data <= fill_word;
            end
        end
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign miss_valid = (state_q == ST_MISS_WAIT);
    assign miss_paddr = {ppn_q, PAGE_OFF_W'(0)} | PA_W'({idx_q, {OFF_W{1'b0}}});

    // R5
    way_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R4
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R2
    rsp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (req_ready && !miss_valid));

    // R6
    miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && !fill_valid) |=> (miss_valid && $stable(miss_paddr)));

    // R3
    xlat_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !miss_valid && !rsp_valid && xlat_valid && !xlat_hit)
        |=> (!req_ready && !rsp_valid && !miss_valid));
endmodule

// File: tb/tb_vipt_lookup.sv
`timescale 1ns/1ps
module tb_vipt_lookup;
    localparam int SETS = 64;
    localparam int WAYS = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid;
    logic [47:0]  req_va;
    logic         req_ready;
    logic         xlat_valid, xlat_hit;
    logic [39:0]  xlat_ppn;
    logic         rsp_valid, rsp_hit;
    logic [63:0]  rsp_data;
    logic         miss_valid;
    logic [51:0]  miss_paddr;
    logic         fill_valid;
    logic [511:0] fill_data;

    always #10 clk = ~clk;

    vipt_lookup dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_ready(req_ready), .xlat_valid(xlat_valid), .xlat_hit(xlat_hit),
        .xlat_ppn(xlat_ppn), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_data(rsp_data), .miss_valid(miss_valid), .miss_paddr(miss_paddr),
        .fill_valid(fill_valid), .fill_data(fill_data)
    );

    int checks = 0;
    int errors = 0;

    // Reference state: residency and last-use stamps per way.
    bit          m_valid [SETS][WAYS];
    logic [39:0] m_ppn   [SETS][WAYS];
    int          m_stamp [SETS][WAYS];
    int          stamp_ctr = 100;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] word_of(logic [39:0] ppn, int set, int k);
        return {ppn[31:0], 8'hC3, 8'(set), 8'(k), 8'h5A};
    endfunction

    function automatic logic [511:0] line_of(logic [39:0] ppn, int set);
        logic [511:0] l;
        for (int k = 0; k < 8; k++) l[k*64 +: 64] = word_of(ppn, set, k);
        return l;
    endfunction

    function automatic logic [39:0] ppn_of(int set, int n);
        return 40'h80_0000_0000 | (40'(set) << 8) | 40'(n);
    endfunction

    task automatic access(int set, logic [39:0] ppn, int k, int nwait, string tag);
        logic [47:0] va;
        int hw;
        int vw;
        hw = -1;
        for (int w = 0; w < WAYS; w++)
            if (m_valid[set][w] && m_ppn[set][w] == ppn) hw = w;
        va = {$urandom(), $urandom()};
        va[11:6] = 6'(set);
        va[5:3]  = 3'(k);
        @(negedge clk);
        req_valid = 1'b1; req_va = va;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 ready low after accept", 64'(req_ready), 64'd0);
        for (int i = 0; i < nwait; i++) begin
            xlat_valid = 1'b1; xlat_hit = 1'b0; xlat_ppn = ppn ^ 40'h1;
            @(negedge clk);
            chk("R3 parked on translation miss",
                64'({req_ready, rsp_valid, miss_valid}), 64'd0);
        end
        xlat_valid = 1'b1; xlat_hit = 1'b1; xlat_ppn = ppn;
        @(negedge clk);
        xlat_valid = 1'b0;
        if (hw >= 0) begin
            chk({tag, " R4 hit response"}, 64'({rsp_valid, rsp_hit, miss_valid}), 64'b110);
            chk("R4 R10 hit word", rsp_data, word_of(ppn, set, k));
            m_stamp[set][hw] = stamp_ctr++;
            @(negedge clk);
            chk("R4 single-cycle response", 64'({rsp_valid, req_ready}), 64'b01);
        end else begin
            chk({tag, " R5 miss raised"}, 64'({rsp_valid, miss_valid}), 64'b01);
            chk("R6 miss address", 64'(miss_paddr), 64'({ppn, 6'(set), 6'd0}));
            @(negedge clk);
            chk("R6 miss held", 64'({miss_valid, req_ready}), 64'b10);
            chk("R6 miss address stable", 64'(miss_paddr), 64'({ppn, 6'(set), 6'd0}));
            fill_valid = 1'b1; fill_data = line_of(ppn, set);
            @(negedge clk);
            fill_valid = 1'b0;
            chk("R7 fill response", 64'({rsp_valid, rsp_hit, miss_valid, req_ready}),
                64'b1001);
            chk("R7 R10 fill word", rsp_data, word_of(ppn, set, k));
            vw = 0;
            for (int w = 1; w < WAYS; w++)
                if (m_stamp[set][w] < m_stamp[set][vw]) vw = w;
            m_valid[set][vw] = 1'b1;
            m_ppn[set][vw]   = ppn;
            m_stamp[set][vw] = stamp_ctr++;
            @(negedge clk);
            chk("R7 single-cycle response", 64'(rsp_valid), 64'd0);
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int sweep [4];
        rst_n = 1'b0; req_valid = 1'b0; req_va = '0;
        xlat_valid = 1'b0; xlat_hit = 1'b0; xlat_ppn = '0;
        fill_valid = 1'b0; fill_data = '0;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_valid[s][w] = 1'b0;
                m_ppn[s][w]   = '0;
                m_stamp[s][w] = WAYS - 1 - w;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset outputs", 64'({req_ready, rsp_valid, miss_valid}), 64'b100);

        // R1 R5: an all-zero page number must miss on an invalid fresh set.
        access(5, 40'd0, 2, 0, "R1 R5 invalid line");

        sweep = '{0, 1, 2, 63};
        foreach (sweep[i]) begin
            int s;
            s = sweep[i];
            for (int n = 0; n < WAYS; n++) access(s, ppn_of(s, n), n, n % 3, "R9 cold fill");
            for (int n = 0; n < WAYS; n++) access(s, ppn_of(s, n), 7 - n, 1, "R5 resident");
            access(s, ppn_of(s, 8), 3, 0, "R9 new page evicts");
            access(s, ppn_of(s, 0), 4, 2, "R9 evicted page misses");
            access(s, ppn_of(s, 7), 6, 0, "R9 recent page kept");
            access(s, ppn_of(s, 2), 1, 0, "R9 middle page kept");
        end

        // R5: tag differs only in the top bit
        access(0, ppn_of(0, 7) ^ (40'd1 << 39), 0, 0, "R5 top-bit mismatch");

        // R8: stray refill while idle
        @(negedge clk);
        fill_valid = 1'b1; fill_data = {8{64'hDEAD_BEEF_0BAD_F00D}};
        @(negedge clk);
        fill_valid = 1'b0;
        chk("R8 stray fill no response", 64'({rsp_valid, req_ready, miss_valid}), 64'b010);
        access(9, ppn_of(9, 1), 5, 0, "R8 stray fill did not allocate");
        access(9, ppn_of(9, 1), 2, 0, "R8 line intact");
        access(1, ppn_of(1, 7), 0, 1, "R8 older line intact");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule